// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block makes the SCL clock for an I2C master and tells the transfer sequencer when to move SDA and when to sample it. All timing comes from one 32-bit configuration word. The word holds a prescaler, a data-setup count, a data-hold count, and the counts for the SCL low and high phases. The word and a noise-filter length are captured only while the block is disabled.

Both bus lines pass through a two-flop synchronizer and then an optional digital glitch filter before the block uses them. The generator pulls SCL low, waits until the filtered line is low, and then counts the low phase. It releases SCL, waits until the filtered line is high, and then counts the high phase. Because the line level gates each phase, a slave that holds SCL low (clock stretching) delays the clock edge by the same number of cycles, and a slower master on the bus sets the shared phase. Inside each low phase, a hold delay marks the cycle in which the sequencer may change SDA. A setup delay then runs before SCL may be released.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: The configuration word fields are: prescaler P at bits 31:28, setup count U at 23:20, hold count A at 19:16, high count Hc at 15:8 and low count Lc at 7:0. Bits 27:24 are reserved and must be zero. The word and the filter length d (0..16; values above 16 act as 16) are captured on every clock while `enable` is low.
- R2: With no other device on the bus, `scl_drive_low` stays high for exactly 5 + d + max((Lc+1)(P+1), A(P+1)+1 + (U+1)(P+1)) cycles. This includes the first low phase that follows idle.
- R3: With no stretching, `scl_drive_low` stays low for exactly 5 + d + (Hc+1)(P+1) cycles. If the bus line is held low for K extra cycles after release, this interval grows by exactly K.
- R4: `drive_strobe` is a one-cycle pulse, once per low phase. It occurs 4 + d + A(P+1) + 1 cycles after `scl_drive_low` rises, and only while `scl_drive_low` is high.
- R5: `sample_strobe` is a one-cycle pulse, once per high phase. It occurs 4 + d cycles after the bus line is released high, and only while `scl_drive_low` is low.
- R6: `scl_filt` and `sda_filt` take a new line level only after the synchronized line has differed from the filtered value on d+1 consecutive clocks. A change therefore appears 3 + d cycles after the line moves, and a pulse of d cycles or fewer never appears. A value of d = 0 leaves only the synchronizer.
- R7: While `enable` is low, `scl_drive_low` is low from the next cycle on and no strobe occurs. When `run` is low at the end of a high phase, the generator stops with SCL released.
- R8: During and after reset, `scl_drive_low`, `sample_strobe` and `drive_strobe` are low and both filtered lines read high.
- R9: A configuration word presented while `enable` is high has no effect on timing until `enable` has been low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low captures the configuration |
| run | input | 1 | Sequencer request to keep clocking |
| timing_word | input | 32 | Packed timing configuration |
| dnf_len | input | 5 | Digital filter length in clocks |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (open-drain enable) |
| scl_filt | output | 1 | Synchronized, filtered SCL |
| sda_filt | output | 1 | Synchronized, filtered SDA |
| sample_strobe | output | 1 | Pulse: SCL seen high, sample SDA |
| drive_strobe | output | 1 | Pulse: hold time met, SDA may change |

## Verification
A table of configurations is run through the generator. Some phases are set by the low count and some by the setup-plus-hold sum, and the table covers prescalers above one and filter lengths of 0, 1, 2 and 16. This separates an error in the maximum selection, in prescaler scaling and in filter latency. A slave that stretches the clock shows that the high phase follows the line and not a free-running divider. SDA pulses of exactly d and d+1 cycles mark the edge of the filter's acceptance. A word written while the block is enabled, and dropping enable in the middle of a phase, exercise the capture and shutdown rules.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;
  localparam int PRESC_W = 4;
  localparam int SETUP_W = 4;
  localparam int HOLD_W  = 4;
  localparam int HIGH_W  = 8;
  localparam int LOW_W   = 8;
  localparam int DNF_W   = 5;
  localparam int DNF_MAX = 16;
  localparam int UNIT_W  = 9;
  localparam int HOLD_CW = HOLD_W + PRESC_W + 1;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [SETUP_W-1:0] setup;
    logic [HOLD_W-1:0]  hold;
    logic [HIGH_W-1:0]  high;
    logic [LOW_W-1:0]   low;
  } tg_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW_WAIT, ST_LOW, ST_HIGH_WAIT, ST_HIGH
  } tg_state_e;

  function automatic tg_cfg_t unpack_word(input logic [31:0] w);
    tg_cfg_t c;
    c.presc = w[31:28];
    c.setup = w[23:20];
    c.hold  = w[19:16];
    c.high  = w[15:8];
    c.low   = w[7:0];
    return c;
  endfunction
endpackage

// File: rtl/tg_line_filter.sv
module tg_line_filter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] dnf,
  input  logic             raw,
  output logic             filt
);
  logic             s1_q;
  logic             s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      filt  <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s2_q == filt) begin
        cnt_q <= '0;
      end else if (cnt_q >= dnf) begin
        filt  <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> (filt == $past(s2_q))); // R6
endmodule

// File: rtl/tg_unit_timer.sv
module tg_unit_timer #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] units,
  output logic             done
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] unit_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q  <= '0;
      unit_q <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      pre_q  <= '0;
      unit_q <= '0;
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      if (pre_q == presc) begin
        pre_q <= '0;
        if (unit_q == units - CNT_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (rst || clear)
    busy_q |-> (unit_q < units)); // R2
endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
  import i2c_tgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        run,
  input  logic [31:0] timing_word,
  input  logic [4:0]  dnf_len,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_drive_low,
  output logic        scl_filt,
  output logic        sda_filt,
  output logic        sample_strobe,
  output logic        drive_strobe
);
  localparam int NLINES = 2;

  tg_cfg_t            cfg_q;
  logic [DNF_W-1:0]   dnf_q;
  tg_state_e          state_q, state_n;
  logic [HOLD_CW-1:0] hold_q;
  logic [HOLD_CW-1:0] hold_clks;
  logic [UNIT_W-1:0]  low_units, high_units, setup_units, phase_units;
  logic               ph_start, ph_done, su_start, su_done;
  logic               in_low;
  logic [NLINES-1:0]  line_raw, line_filt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      dnf_q <= '0;
    end else if (!enable) begin
      cfg_q <= unpack_word(timing_word);
      dnf_q <= (dnf_len > DNF_W'(DNF_MAX)) ? DNF_W'(DNF_MAX) : dnf_len;
    end
  end

  assign line_raw = {sda_in, scl_in};
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    tg_line_filter #(.CNT_W(DNF_W)) u_filt (
      .clk (clk),
      .rst (rst),
      .dnf (dnf_q),
      .raw (line_raw[g]),
      .filt(line_filt[g])
    );
  end
  assign scl_filt = line_filt[0];
  assign sda_filt = line_filt[1];

  assign low_units   = UNIT_W'(cfg_q.low) + UNIT_W'(1);
  assign high_units  = UNIT_W'(cfg_q.high) + UNIT_W'(1);
  assign setup_units = UNIT_W'(cfg_q.setup) + UNIT_W'(1);
  assign in_low      = (state_q == ST_LOW_WAIT) || (state_q == ST_LOW);
  assign phase_units = in_low ? low_units : high_units;
  assign hold_clks   = HOLD_CW'(cfg_q.hold) * (HOLD_CW'(cfg_q.presc) + HOLD_CW'(1))
                       + HOLD_CW'(1);

  assign ph_start = enable &&
                    (((state_q == ST_LOW_WAIT) && !scl_filt) ||
                     ((state_q == ST_HIGH_WAIT) && scl_filt));
  assign su_start = enable && (state_q == ST_LOW) && (hold_q == HOLD_CW'(1));

  tg_unit_timer #(.PRE_W(PRESC_W), .CNT_W(UNIT_W)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .clear(state_q == ST_IDLE),
    .start(ph_start),
    .presc(cfg_q.presc),
    .units(phase_units),
    .done (ph_done)
  );

  tg_unit_timer #(.PRE_W(PRESC_W), .CNT_W(UNIT_W)) u_setup (
    .clk  (clk),
    .rst  (rst),
    .clear(state_q != ST_LOW),
    .start(su_start),
    .presc(cfg_q.presc),
    .units(setup_units),
    .done (su_done)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:      if (run) state_n = ST_LOW_WAIT;
      ST_LOW_WAIT:  if (!scl_filt) state_n = ST_LOW;
      ST_LOW:       if (ph_done && su_done) state_n = ST_HIGH_WAIT;
      ST_HIGH_WAIT: if (scl_filt) state_n = ST_HIGH;
      ST_HIGH:      if (ph_done) state_n = run ? ST_LOW_WAIT : ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
    if (!enable) state_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      scl_drive_low <= 1'b0;
      sample_strobe <= 1'b0;
      drive_strobe  <= 1'b0;
      hold_q        <= '0;
    end else begin
      state_q       <= state_n;
      scl_drive_low <= (state_n == ST_LOW_WAIT) || (state_n == ST_LOW);
      sample_strobe <= enable && (state_q == ST_HIGH_WAIT) && scl_filt;
      drive_strobe  <= su_start;
      if (state_q == ST_LOW_WAIT && !scl_filt)
        hold_q <= hold_clks;
      else if (state_q != ST_LOW)
        hold_q <= '0;
      else if (hold_q != '0)
        hold_q <= hold_q - 1'b1;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (timing_word[27:24] == 4'h0)); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(cfg_q)); // R9
  AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    drive_strobe |-> scl_drive_low); // R4
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |-> !scl_drive_low); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |=> !sample_strobe); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_drive_low && !drive_strobe && !sample_strobe)); // R7
endmodule

// File: tb/i2c_scl_timing_gen_tb_top.sv
module i2c_scl_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic [31:0] timing_word = '0;
  logic [4:0]  dnf_len = '0;
  logic        slave_low = 1'b0;
  logic        sda_raw = 1'b1;
  logic        scl_drive_low, scl_filt, sda_filt, sample_strobe, drive_strobe;
  logic        scl_bus;
  int          checks = 0;
  int          failures = 0;

  always #4 clk = ~clk;
  assign scl_bus = !(scl_drive_low || slave_low);

  i2c_scl_timing_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .run          (run),
    .timing_word  (timing_word),
    .dnf_len      (dnf_len),
    .scl_in       (scl_bus),
    .sda_in       (sda_raw),
    .scl_drive_low(scl_drive_low),
    .scl_filt     (scl_filt),
    .sda_filt     (sda_filt),
    .sample_strobe(sample_strobe),
    .drive_strobe (drive_strobe)
  );

  // presc, setup, hold, high, low, dnf, exp_low, exp_high, exp_hold_off
  localparam int NV = 5;
  localparam int VEC [NV][9] = '{
    '{0, 1, 2, 3, 4,  0, 10,  9,  7},
    '{1, 0, 1, 5, 2,  2, 13, 19,  9},
    '{0, 7, 6, 1, 1,  0, 20,  7, 11},
    '{3, 2, 0, 0, 0, 16, 34, 25, 21},
    '{2, 3, 4, 9, 14, 1, 51, 36, 18}
  };

  function automatic logic [31:0] mk_word(int p, int u, int a, int h, int l);
    return {4'(p), 4'h0, 4'(u), 4'(a), 8'(h), 8'(l)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [31:0] w, input int d);
    @(negedge clk);
    run = 1'b0;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    timing_word = w;
    dnf_len = 5'(d);
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic measure(input int stretch, output int lo, output int ho,
                         output int hi, output int so);
    int guard = 0;
    lo = 0; ho = -1; hi = 0; so = -1;
    while (!scl_drive_low && guard < 5000) begin @(negedge clk); guard++; end
    while (scl_drive_low && guard < 5000) begin
      lo++;
      if (drive_strobe) ho = lo - 1;
      if (stretch > 0) slave_low = 1'b1;
      @(negedge clk); guard++;
    end
    while (!scl_drive_low && guard < 5000) begin
      hi++;
      if (sample_strobe) so = hi - 1;
      if (hi == stretch + 1) slave_low = 1'b0;
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lo, ho, hi, so, bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 drive_low", scl_drive_low, 0);
    chk("R8 strobes", sample_strobe | drive_strobe, 0);
    chk("R8 scl_filt", scl_filt, 1);
    chk("R8 sda_filt", sda_filt, 1);

    // R1 R2 R3 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      configure(mk_word(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]), VEC[i][5]);
      run = 1'b1;
      measure(0, lo, ho, hi, so);
      run = 1'b0;
      chk("R2 low length", lo, VEC[i][6]);
      chk("R3 high length", hi, VEC[i][7]);
      chk("R4 drive strobe offset", ho, VEC[i][8]);
      chk("R5 sample strobe offset", so, 4 + VEC[i][5]);
      repeat (300) @(negedge clk);
    end

    // R3 R5: clock stretching by 10 cycles, vector 0
    configure(mk_word(0, 1, 2, 3, 4), 0);
    run = 1'b1;
    measure(10, lo, ho, hi, so);
    run = 1'b0;
    chk("R3 stretched high", hi, 19);
    chk("R5 stretched sample offset", so, 14);
    repeat (300) @(negedge clk);

    // R7: run low leaves SCL released
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (scl_drive_low || sample_strobe || drive_strobe) bad++;
    end
    chk("R7 idle without run", bad, 0);

    // R9: word written while enabled is ignored
    timing_word = mk_word(0, 7, 6, 1, 1);
    repeat (3) @(negedge clk);
    run = 1'b1;
    measure(0, lo, ho, hi, so);
    run = 1'b0;
    chk("R9 old low length kept", lo, 10);
    repeat (300) @(negedge clk);
    configure(mk_word(0, 7, 6, 1, 1), 0);
    run = 1'b1;
    measure(0, lo, ho, hi, so);
    chk("R9 new low length after disable", lo, 20);

    // R7: enable dropped during a low phase
    while (!scl_drive_low) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R7 release after disable", scl_drive_low, 0);
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (scl_drive_low || sample_strobe || drive_strobe) bad++;
    end
    chk("R7 quiet while disabled", bad, 0);
    run = 1'b0;

    // R6: filter length 4, SDA pulse of 4 cycles is rejected
    configure(mk_word(0, 0, 0, 0, 0), 4);
    @(negedge clk);
    sda_raw = 1'b0;
    bad = 0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (c == 4) sda_raw = 1'b1;
      if (!sda_filt) bad++;
    end
    chk("R6 short pulse rejected", bad, 0);
    // R6: SDA pulse of 5 cycles passes after 3+d cycles
    sda_raw = 1'b0;
    for (int c = 1; c <= 7; c++) begin
      @(negedge clk);
      if (c == 5) sda_raw = 1'b1;
      if (c == 6) chk("R6 before latency", sda_filt, 1);
      if (c == 7) chk("R6 at latency", sda_filt, 0);
    end
    repeat (30) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule